// File: doc/BRIEF.md
# Code-Protect Aware Programming Checksum Accumulator

This block adds up a stream of memory words read from a small one-time-programmable program store and produces the 16-bit checksum that a production programmer reports. Each accepted word carries its 14-bit address, its 14-bit value, a start marker on the first word of a stream and a last marker on the final one. Program words land in user space (addresses below 0x2000). The configuration word sits at 0x2007 and four identification words sit at 0x2000 to 0x2003, all in configuration space.

The code-protection field of the configuration word selects which program addresses count toward the sum. When protection is active, the low nibbles of the four identification words are packed into one 16-bit term and added as well. The configuration word may arrive anywhere in the stream. The block keeps three partial sums, one for each protection boundary, and picks among them only when the last word arrives. The program memory size (1024 or 2048 words) is a parameter. The top word of the implemented memory holds the oscillator calibration word and never counts.

Top module: `prog_cksum_acc`

## Requirements
- R1: The checksum is the sum of all contributions truncated to 16 bits; carries out of bit 15 are dropped.
- R2: Some words never change the result. These are the word at address MEM_WORDS-1 (the calibration word), program addresses at or above MEM_WORDS, and configuration-space addresses other than 0x2000 to 0x2003 and 0x2007.
- R3: The protection level is read from configuration bits 5:4. The code 2'b11 means no protection. The code 2'b10 protects 0x400 and up, but only when MEM_WORDS is 2048; with 1024 words it acts as no protection. The code 2'b01 protects 0x200 and up. The code 2'b00 protects all program memory.
- R4: If any of the pairs at configuration bits 13:12, 11:10 or 9:8 differs from bits 5:4, the level is no protection.
- R5: With no protection, the checksum is the sum of program words from address 0 to MEM_WORDS-2 plus the configuration word. No ID term is added.
- R6: With partial protection, only the program words below the protected boundary are summed, plus the configuration word and the ID term. With full protection, only the configuration word and the ID term are summed.
- R7: The ID term is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, where idN is the word at address 0x2000+N. For example, 0x12, 0x37, 0x04 and 0x26 give 0x2746.
- R8: The result does not depend on where the configuration word and the ID words sit within the stream.
- R9: A configuration word missing from a stream counts as 0x3FFF. A missing ID word counts as nibble 0xF.
- R10: A valid word with the start marker begins a new stream and discards all earlier partial sums and captured words. It also clears the done flag, unless the same word carries the last marker.
- R11: Checksum and done appear in the cycle after the last-marked word is accepted and hold until the next start. After reset, the checksum is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word present this cycle |
| in_start | input | 1 | First word of a stream |
| in_last | input | 1 | Final word of a stream |
| in_addr | input | ADDR_W | Word address |
| in_data | input | WORD_W | Word value |
| cksum | output | SUM_W | Checksum of the last completed stream |
| cksum_done | output | 1 | Checksum valid |

## Verification
The bench sends one fixed stream under six configuration words to a 2048-word and a 1024-word instance. The stream places data at every protection boundary, at the calibration address, past the end of memory and at a reserved configuration address. If a boundary were off by one, or the calibration word were counted, one of the two results would move by a known power-of-two amount. The mismatched-pair configurations show up a decoder that reads only one pair, because such a decoder would drop program words and add the ID term. Directed streams cover three more cases. A stream with the configuration word sent first catches a design that decides the protection level as words arrive. A stream with no configuration or ID words exposes wrong defaults, and a wide sum catches a design that saturates or keeps the carry.

// File: rtl/ckacc_pkg.sv
package ckacc_pkg;
  typedef enum logic [1:0] {
    LVL_NONE       = 2'd0,
    LVL_UPPER_HALF = 2'd1,
    LVL_UPPER_3Q   = 2'd2,
    LVL_ALL        = 2'd3
  } prot_lvl_e;

  localparam int BOUND_QUARTER = 512;
  localparam int BOUND_HALF    = 1024;
  localparam int N_BINS        = 3;
  localparam int N_IDS         = 4;
  localparam int NIB_W         = 4;
endpackage

// File: rtl/ckacc_prot_decode.sv
module ckacc_prot_decode
  import ckacc_pkg::*;
#(
  parameter int MEM_WORDS = 2048
) (
  input  logic [5:0] pairs_i,
  input  logic [1:0] field_i,
  output prot_lvl_e  lvl_o
);
  localparam bit HAS_UPPER_HALF = (MEM_WORDS > BOUND_HALF);

  logic consistent;

  always_comb begin
    consistent = (pairs_i[5:4] == field_i) && (pairs_i[3:2] == field_i) &&
                 (pairs_i[1:0] == field_i);
    lvl_o = LVL_NONE;
    if (consistent) begin
      unique case (field_i)
        2'b11: lvl_o = LVL_NONE;
        2'b10: lvl_o = HAS_UPPER_HALF ? LVL_UPPER_HALF : LVL_NONE;
        2'b01: lvl_o = LVL_UPPER_3Q;
        default: lvl_o = LVL_ALL;
      endcase
    end
  end
endmodule

// File: rtl/ckacc_bins.sv
module ckacc_bins
  import ckacc_pkg::*;
#(
  parameter int MEM_WORDS = 2048,
  parameter int ADDR_W    = 14,
  parameter int WORD_W    = 14,
  parameter int SUM_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vld_i,
  input  logic                          first_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             data_i,
  output logic [N_BINS-1:0][SUM_W-1:0]  bin_nxt_o
);
  localparam logic [ADDR_W-1:0] CAL_ADDR = ADDR_W'(MEM_WORDS - 1);

  function automatic int bin_lo(input int b);
    return (b == 0) ? 0 : ((b == 1) ? BOUND_QUARTER : BOUND_HALF);
  endfunction

  function automatic int bin_hi(input int b);
    return (b == 0) ? BOUND_QUARTER : ((b == 1) ? BOUND_HALF : MEM_WORDS - 1);
  endfunction

  logic [N_BINS-1:0][SUM_W-1:0] bin_q;

  for (genvar b = 0; b < N_BINS; b++) begin : g_bin
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(bin_lo(b));
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(bin_hi(b));
    logic hit;

    always_comb begin
      hit = (addr_i >= LO_A) && (addr_i < HI_A) && (addr_i < CAL_ADDR);
      bin_nxt_o[b] = first_i ? '0 : bin_q[b];
      if (hit) bin_nxt_o[b] = bin_nxt_o[b] + SUM_W'(data_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bin_q[b] <= '0;
      else if (vld_i) bin_q[b] <= bin_nxt_o[b];
    end
  end

  AST_CAL_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && !first_i && addr_i == CAL_ADDR |=> $stable(bin_q)); // R2
  AST_BEYOND_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && !first_i && addr_i >= ADDR_W'(MEM_WORDS) |=> $stable(bin_q)); // R2
endmodule

// File: rtl/ckacc_cfg_capture.sv
module ckacc_cfg_capture
  import ckacc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WORD_W = 14,
  parameter int SUM_W  = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h2007,
  parameter logic [ADDR_W-1:0] ID_BASE  = 14'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] cfg_nxt_o,
  output logic [SUM_W-1:0]  id_pack_nxt_o
);
  logic [WORD_W-1:0]            cfg_q;
  logic [N_IDS-1:0][NIB_W-1:0]  id_q;
  logic [N_IDS-1:0][NIB_W-1:0]  id_nxt;

  always_comb begin
    cfg_nxt_o = first_i ? '1 : cfg_q;
    if (addr_i == CFG_ADDR) cfg_nxt_o = data_i;
  end

  for (genvar k = 0; k < N_IDS; k++) begin : g_id
    localparam logic [ADDR_W-1:0] ID_A = ID_BASE + ADDR_W'(k);
    always_comb begin
      id_nxt[k] = first_i ? '1 : id_q[k];
      if (addr_i == ID_A) id_nxt[k] = data_i[NIB_W-1:0];
    end
    // id0 lands in the most significant nibble
    assign id_pack_nxt_o[SUM_W-1-k*NIB_W -: NIB_W] = id_nxt[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
      id_q  <= '1;
    end else if (vld_i) begin
      cfg_q <= cfg_nxt_o;
      id_q  <= id_nxt;
    end
  end

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && !first_i && addr_i == ID_BASE + ADDR_W'(N_IDS)
    |=> $stable(cfg_q) && $stable(id_q)); // R2
endmodule

// File: rtl/prog_cksum_acc.sv
module prog_cksum_acc
  import ckacc_pkg::*;
#(
  parameter int MEM_WORDS = 2048,
  parameter int ADDR_W    = 14,
  parameter int WORD_W    = 14,
  parameter int SUM_W     = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h2007,
  parameter logic [ADDR_W-1:0] ID_BASE  = 14'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  output logic [SUM_W-1:0]  cksum,
  output logic              cksum_done
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                         first;
  logic [N_BINS-1:0][SUM_W-1:0] bin_nxt;
  logic [WORD_W-1:0]            cfg_nxt;
  logic [SUM_W-1:0]             id_pack_nxt;
  prot_lvl_e                    lvl;

  assign first = in_valid && in_start;

  ckacc_bins #(
    .MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_W(SUM_W)
  ) u_bins (
    .clk(clk), .rst_n(rst_n_s), .vld_i(in_valid), .first_i(first),
    .addr_i(in_addr), .data_i(in_data), .bin_nxt_o(bin_nxt)
  );

  ckacc_cfg_capture #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_W(SUM_W),
    .CFG_ADDR(CFG_ADDR), .ID_BASE(ID_BASE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .vld_i(in_valid), .first_i(first),
    .addr_i(in_addr), .data_i(in_data),
    .cfg_nxt_o(cfg_nxt), .id_pack_nxt_o(id_pack_nxt)
  );

  ckacc_prot_decode #(.MEM_WORDS(MEM_WORDS)) u_dec (
    .pairs_i(cfg_nxt[13:8]), .field_i(cfg_nxt[5:4]), .lvl_o(lvl)
  );

  logic [SUM_W-1:0] prog_part, id_part, total;

  always_comb begin
    prog_part = '0;
    id_part   = id_pack_nxt;
    unique case (lvl)
      LVL_NONE: begin
        prog_part = bin_nxt[0] + bin_nxt[1] + bin_nxt[2];
        id_part   = '0;
      end
      LVL_UPPER_HALF: prog_part = bin_nxt[0] + bin_nxt[1];
      LVL_UPPER_3Q:   prog_part = bin_nxt[0];
      default:        prog_part = '0;
    endcase
    total = prog_part + SUM_W'(cfg_nxt) + id_part;
  end

  logic             done_nxt, done_en, sum_en;

  always_comb begin
    sum_en   = in_valid && in_last;
    done_en  = in_valid && (in_last || in_start);
    done_nxt = in_last;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cksum      <= '0;
      cksum_done <= 1'b0;
    end else begin
      if (sum_en)  cksum      <= total;
      if (done_en) cksum_done <= done_nxt;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid && in_last |=> cksum_done); // R11
  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid && in_start && !in_last |=> !cksum_done); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(in_valid && (in_last || in_start)) |=> $stable(cksum) && $stable(cksum_done)); // R11
endmodule

// File: tb/prog_cksum_acc_bench.sv
module prog_cksum_acc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [13:0] in_addr = '0, in_data = '0;
  logic [15:0] sum2k, sum1k;
  logic        done2k, done1k;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  prog_cksum_acc #(.MEM_WORDS(2048)) u_prog_cksum_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_addr(in_addr), .in_data(in_data),
    .cksum(sum2k), .cksum_done(done2k));

  prog_cksum_acc #(.MEM_WORDS(1024)) u_prog_cksum_acc_1k (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_addr(in_addr), .in_data(in_data),
    .cksum(sum1k), .cksum_done(done1k));

  // Stream: entry 5 is the configuration word, its value taken from the vector.
  localparam int NW = 15;
  localparam logic [13:0] S_ADDR [NW] = '{
    14'h000, 14'h1FF, 14'h200, 14'h3FE, 14'h3FF, 14'h2007, 14'h400, 14'h2000,
    14'h2001, 14'h2002, 14'h2003, 14'h7FE, 14'h7FF, 14'h800, 14'h2004};
  localparam logic [13:0] S_DATA [NW] = '{
    14'h3FFF, 14'h0001, 14'h0010, 14'h0100, 14'h1000, 14'h0000, 14'h2000, 14'h0012,
    14'h0037, 14'h0004, 14'h0026, 14'h0002, 14'h3000, 14'h0123, 14'h0555};

  // {cfg, expected 2K, expected 1K}
  localparam int NV = 6;
  localparam logic [45:0] VEC [NV] = '{
    {14'h3FFF, 16'hB111, 16'h810F},   // R5 off; R2 cal/beyond/reserved skipped
    {14'h2AEF, 16'hA345, 16'h6BFF},   // R3 code 10; R6 R7 on 2K, off on 1K
    {14'h15DF, 16'h7D25, 16'h7D25},   // R3 code 01; R6 R7
    {14'h00CF, 16'h2815, 16'h2815},   // R3 code 00; R6 full
    {14'h0FFF, 16'h8111, 16'h510F},   // R4 top pair mismatched
    {14'h30CF, 16'hA1E1, 16'h71DF}};  // R4 field 00 but top pair 11

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic put(input logic [13:0] a, input logic [13:0] d, input logic s, input logic l);
    in_valid = 1'b1; in_start = s; in_last = l; in_addr = a; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset checksum", sum2k, 16'h0000);
    check("R11 reset done", {15'b0, done2k}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < NW; w++) begin
        put(S_ADDR[w], (w == 5) ? VEC[v][45:32] : S_DATA[w], w == 0, w == NW - 1);
      end
      check($sformatf("R3 R4 R5 R6 vec%0d 2K", v), sum2k, VEC[v][31:16]);
      check($sformatf("R2 R3 R6 vec%0d 1K", v), sum1k, VEC[v][15:0]);
      check("R11 done after last", {15'b0, done2k & done1k}, 16'h0001);
    end

    // R10: a start word alone drops done
    put(14'h000, 14'h3FFF, 1'b1, 1'b0);
    check("R10 done cleared by start", {15'b0, done2k}, 16'h0000);
    // R1: six words of 0x3FFF wrap past 16 bits; no cfg word so blank cfg (R9)
    for (int i = 1; i < 5; i++) put(14'(i), 14'h3FFF, 1'b0, i == 4);
    check("R1 wrap 2K", sum2k, 16'h7FFA);
    check("R1 wrap 1K", sum1k, 16'h7FFA);

    // R8 R9: cfg first, no IDs (nibbles F)
    put(14'h2007, 14'h15DF, 1'b1, 1'b0);
    put(14'h000, 14'h3FFF, 1'b0, 1'b0);
    put(14'h1FF, 14'h0001, 1'b0, 1'b0);
    put(14'h200, 14'h0010, 1'b0, 1'b1);
    check("R8 R9 cfg first 2K", sum2k, 16'h55DE);
    check("R8 R9 cfg first 1K", sum1k, 16'h55DE);

    // R10 R11: single word carrying start and last
    put(14'h2007, 14'h00CF, 1'b1, 1'b1);
    check("R10 single-word stream", sum2k, 16'h00CE);
    check("R11 single-word done", {15'b0, done2k}, 16'h0001);

    // R9: no cfg word at all
    put(14'h001, 14'h0005, 1'b1, 1'b0);
    put(14'h002, 14'h0007, 1'b0, 1'b1);
    check("R9 blank cfg 2K", sum2k, 16'h400B);
    check("R9 blank cfg 1K", sum1k, 16'h400B);

    // R11: result holds while idle
    repeat (5) @(negedge clk);
    check("R11 result held", sum2k, 16'h400B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule